// File: doc/BRIEF.md
# Serial-Loaded Storage Register with Readback

This block pairs a 16-bit shift register with a 16-bit storage latch whose contents drive a parallel output bus. A single serial line carries data in both directions, and the read/write select sets its direction. In write mode, bits are clocked into the low end of the shift register, and a rising edge on the strobe input copies the full word into the storage latch. In read mode, a shift pulse with the strobe/mode input held high reloads the shift register from the latch. Later shift pulses with that input low move the word out on the serial line, most significant bit first.

The block runs on a free-running system clock. The shift clock and the strobe/mode input are treated as ordinary signals, and edge detectors sample them on that clock. Each detected rising edge acts in the same system clock cycle in which the new level is first sampled. All serial and control pins are plain level signals. The serial path has no handshake, because the external shift clock sets the pace and the block never applies back-pressure.

Top module: `sreg_store16`

## Requirements
- R1: After system reset, the shift register and the storage latch are both zero, so `par_out` reads 0x0000 and `ser_oe` is low.
- R2: `ser_oe` is 1 only when `cs_n`=0 and `rd_wr`=1 (read). `ser_out` always carries bit 15 of the shift register.
- R3: While `cs_n`=1, edges on `shclk` or `mode_stclk` change neither the shift register nor the latch. After reset, data clocked in while deselected leaves `par_out` at zero, and so does a strobe issued after reselection.
- R4: In write mode (`rd_wr`=0), each rising edge of `shclk` moves every bit one place toward bit 15 and puts `ser_in` into bit 0. Sixteen bits 0,1,0,1,… give 0x5555, and one more 0 gives 0xAAAA.
- R5: In write mode, a rising edge of `mode_stclk` copies the shift register into the latch. In read mode, `mode_stclk` edges never load the latch.
- R6: While `clr_n`=0, the latch is forced to zero on each system clock, even when a storage edge arrives in the same cycle.
- R7: `par_out` always shows the latch and never the live shift register. Shifting without a strobe leaves it unchanged.
- R8: In read mode with `mode_stclk`=1, a rising edge of `shclk` loads the shift register from the latch instead of shifting.
- R9: In read mode with `mode_stclk`=0, each rising edge of `shclk` shifts toward bit 15 and puts 0 into bit 0. A word that has been loaded back appears on `ser_out` MSB first, and after 16 shifts `ser_out` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low system reset, asynchronous |
| cs_n | input | 1 | Active-low select |
| rd_wr | input | 1 | 1 = read (serial line driven out), 0 = write |
| shclk | input | 1 | Shift clock, acts on its rising edge |
| mode_stclk | input | 1 | Storage strobe in write mode; load/shift mode select in read mode |
| clr_n | input | 1 | Active-low latch clear |
| ser_in | input | 1 | Serial line, inbound value |
| ser_out | output | 1 | Serial line, outbound value (shift register bit 15) |
| ser_oe | output | 1 | Serial line output enable |
| par_out | output | 16 | Storage latch contents |

## Verification
The shift register has no port of its own. A wrong bit in it shows up only when a strobe copies it to `par_out`, or when it reaches bit 15 on `ser_out` in read mode, up to 16 shift pulses later. For this reason the bench reloads and shifts out complete words, and it strobes after each deselected sequence. A latch fault shows on `par_out` one system clock after the edge that caused it. A clear or select error shows in that same cycle.

// File: rtl/sreg_store_pkg.sv
package sreg_store_pkg;
  typedef enum logic [1:0] {
    SR_HOLD  = 2'd0,
    SR_SHIFT = 2'd1,
    SR_LOAD  = 2'd2
  } sr_op_e;
endpackage

// File: rtl/sreg_rise_det.sv
module sreg_rise_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise
);
  for (genvar g = 0; g < N; g++) begin : g_det
    logic prev_q;
    // reset high so a level already high at reset release is not an edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= din[g];
    end
    assign rise[g] = din[g] & ~prev_q;
  end
endmodule

// File: rtl/sreg_shift_core.sv
module sreg_shift_core
  import sreg_store_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  sr_op_e       op,
  input  logic         fill,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      unique case (op)
        SR_SHIFT: q <= {q[W-2:0], fill};
        SR_LOAD:  q <= load_val;
        default:  q <= q;
      endcase
    end
  end
endmodule

// File: rtl/sreg_store_latch.sv
module sreg_store_latch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_n,
  input  logic         capture,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (!clr_n)  q <= '0;
    else if (capture) q <= d;
  end
endmodule

// File: rtl/sreg_store16.sv
module sreg_store16
  import sreg_store_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         rd_wr,
  input  logic         shclk,
  input  logic         mode_stclk,
  input  logic         clr_n,
  input  logic         ser_in,
  output logic         ser_out,
  output logic         ser_oe,
  output logic [W-1:0] par_out
);
  localparam int NEDGE = 2;
  localparam int MSB   = W - 1;

  logic [NEDGE-1:0] rise_v;
  logic             sh_rise;
  logic             st_rise;
  logic             fill_bit;
  logic             capture;
  sr_op_e           op;
  logic [W-1:0]     sr_q;
  logic [W-1:0]     latch_q;

  sreg_rise_det #(.N(NEDGE)) u_edges (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({mode_stclk, shclk}),
    .rise (rise_v)
  );

  assign sh_rise = rise_v[0];
  assign st_rise = rise_v[1];

  always_comb begin
    op = SR_HOLD;
    if (!cs_n && sh_rise) op = (rd_wr && mode_stclk) ? SR_LOAD : SR_SHIFT;
  end

  // line is driven out in read mode, so nothing is sampled from it
  assign fill_bit = rd_wr ? 1'b0 : ser_in;
  assign capture  = !cs_n && !rd_wr && st_rise;

  sreg_shift_core #(.W(W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .fill    (fill_bit),
    .load_val(latch_q),
    .q       (sr_q)
  );

  sreg_store_latch #(.W(W)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_n  (clr_n),
    .capture(capture),
    .d      (sr_q),
    .q      (latch_q)
  );

  assign ser_out = sr_q[MSB];
  assign ser_oe  = !cs_n && rd_wr;
  assign par_out = latch_q;
endmodule

// File: rtl/sreg_store16_chk.sv
module sreg_store16_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs_n,
  input logic         rd_wr,
  input logic         mode_stclk,
  input logic         clr_n,
  input logic         ser_in,
  input logic         ser_oe,
  input logic         sh_rise,
  input logic [W-1:0] sr_q,
  input logic [W-1:0] latch_q,
  input logic [W-1:0] par_out
);
  AST_DESEL_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !ser_oe); // R2
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !rd_wr) |-> !ser_oe); // R2
  AST_DESEL_HOLDS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && clr_n) |=> $stable(par_out)); // R3
  AST_DESEL_HOLDS_SR: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(sr_q)); // R3
  AST_WRITE_ENTERS_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !rd_wr && sh_rise) |=> (sr_q[0] == $past(ser_in))); // R4
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (par_out == '0)); // R6
  AST_READ_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && rd_wr && mode_stclk && sh_rise) |=> (sr_q == $past(latch_q))); // R8
  AST_READ_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && rd_wr && !mode_stclk && sh_rise) |=> (sr_q[0] == 1'b0)); // R9
endmodule

bind sreg_store16 sreg_store16_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .rd_wr     (rd_wr),
  .mode_stclk(mode_stclk),
  .clr_n     (clr_n),
  .ser_in    (ser_in),
  .ser_oe    (ser_oe),
  .sh_rise   (sh_rise),
  .sr_q      (sr_q),
  .latch_q   (latch_q),
  .par_out   (par_out)
);

// File: tb/sreg_store16_tb_top.sv
`timescale 1ns/1ps
module sreg_store16_tb_top;
  localparam int W = 16;
  localparam int NPAT = 7;
  localparam logic [W-1:0] PATS [NPAT] = '{
    16'h5555, 16'hAAAA, 16'hFFFF, 16'h0000, 16'h8001, 16'h1234, 16'hC3A5
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b0, rd_wr = 1'b0, shclk = 1'b0, mode_stclk = 1'b0;
  logic clr_n = 1'b1, ser_in = 1'b0;
  logic ser_out, ser_oe;
  logic [W-1:0] par_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sreg_store16 #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_wr(rd_wr), .shclk(shclk),
    .mode_stclk(mode_stclk), .clr_n(clr_n), .ser_in(ser_in),
    .ser_out(ser_out), .ser_oe(ser_oe), .par_out(par_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse_sh(input logic bitv);
    ser_in = bitv;
    shclk = 1'b1; step();
    shclk = 1'b0; step();
  endtask

  task automatic pulse_st();
    mode_stclk = 1'b1; step();
    mode_stclk = 1'b0; step();
  endtask

  task automatic write_word(input logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) pulse_sh(w[i]);
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] rb;
    step(); step();
    // R1 reset state
    chk("R1 par_out after reset", 32'(par_out), 32'h0);
    chk("R1 oe after reset", 32'(ser_oe), 32'h0);
    rst_n = 1'b1; step();

    // R3 deselected clocks are ignored
    cs_n = 1'b1;
    write_word(16'hFFFF);
    pulse_st();
    chk("R3 par_out deselected", 32'(par_out), 32'h0);
    chk("R2 oe deselected", 32'(ser_oe), 32'h0);
    cs_n = 1'b0; step();
    pulse_st();
    chk("R3 shift reg untouched while deselected", 32'(par_out), 32'h0);

    // table walk: R4 / R5 write and strobe
    for (int p = 0; p < NPAT; p++) begin
      write_word(PATS[p]);
      chk("R2 oe in write mode", 32'(ser_oe), 32'h0);
      pulse_st();
      chk("R5 latched pattern", 32'(par_out), 32'(PATS[p]));
    end

    // R4 alternating sequence plus one more zero
    write_word(16'h5555); pulse_st();
    chk("R4 alternating gives 5555", 32'(par_out), 32'h5555);
    pulse_sh(1'b0);
    chk("R7 out unchanged without strobe", 32'(par_out), 32'h5555);
    pulse_st();
    chk("R4 extra zero gives AAAA", 32'(par_out), 32'hAAAA);

    // R6 clear, and clear against a simultaneous strobe
    clr_n = 1'b0; step(); clr_n = 1'b1;
    chk("R6 clear", 32'(par_out), 32'h0);
    write_word(16'h00F0);
    clr_n = 1'b0; mode_stclk = 1'b1; step();
    chk("R6 clear beats strobe", 32'(par_out), 32'h0);
    clr_n = 1'b1; mode_stclk = 1'b0; step();
    chk("R6 cleared latch stays zero", 32'(par_out), 32'h0);

    // readback of C3A5: R2 R5 R7 R8 R9
    write_word(16'hC3A5); pulse_st();
    pulse_sh(1'b1);                         // shift reg now 874B
    chk("R7 latch not live shift reg", 32'(par_out), 32'hC3A5);
    rd_wr = 1'b1; step();
    chk("R2 oe in read mode", 32'(ser_oe), 32'h1);
    chk("R2 ser_out is bit 15", 32'(ser_out), 32'h1);
    mode_stclk = 1'b1; step();
    chk("R5 mode edge in read does not strobe", 32'(par_out), 32'hC3A5);
    pulse_sh(1'b1);
    mode_stclk = 1'b0; step();
    rb = '0;
    for (int i = W - 1; i >= 0; i--) begin
      rb[i] = ser_out;
      pulse_sh(1'b1);
    end
    chk("R8 readback word", 32'(rb), 32'hC3A5);
    chk("R9 zero fill after 16 shifts", 32'(ser_out), 32'h0);

    // R9 doc case: readback 5555 -> 0 then 1
    rd_wr = 1'b0; step();
    write_word(16'h5555); pulse_st();
    rd_wr = 1'b1; mode_stclk = 1'b1; step();
    pulse_sh(1'b0);
    mode_stclk = 1'b0; step();
    chk("R9 first bit of 5555", 32'(ser_out), 32'h0);
    pulse_sh(1'b0);
    chk("R9 second bit of 5555", 32'(ser_out), 32'h1);
    cs_n = 1'b1; step();
    chk("R2 oe off when deselected in read", 32'(ser_oe), 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule